// File: doc/BRIEF.md
# Line Loss-of-Signal Monitor with Data Muting

This block watches a recovered dual-rail line stream, one unit interval (UI) per clock cycle, and decides whether the incoming signal has been lost. A UI in which neither the positive nor the negative rail carries a pulse counts as a zero. A long enough run of consecutive zeros declares loss of signal. The condition is cleared only after the line has shown enough pulses again.

While loss is declared, the block raises a registered clock-source select. Clocking logic downstream uses it to run from an external reference clock in place of the recovered clock. The select and the loss flag always agree. Muting can also be enabled, from either a hardware pin or a per-channel register bit, and the choice between them is made by a mode input. When muting is enabled during a declared loss, both output data rails are forced to zero. At all other times the recovered rails pass straight through.

Top module: `los_mute_detector`

## Requirements
- R1: With the declare threshold T set to 10 or more, loss is declared (los_flag goes to 1) at the clock edge that samples the T-th consecutive zero UI. A zero UI is one with rx_pos=0 and rx_neg=0. Fewer than T consecutive zeros leave los_flag at 0.
- R2: A declare threshold below 10 behaves as 10. The largest threshold, 255, declares on the 255th consecutive zero.
- R3: While loss is declared, los_flag returns to 0 at the edge that samples the 32nd pulse UI. A pulse UI is one with rx_pos=1 or rx_neg=1. After 31 pulse UIs, los_flag is still 1.
- R4: While loss is declared, a run of 32 consecutive zero UIs discards the pulses counted so far. A full 32 further pulses are then needed to clear.
- R5: ref_clk_sel equals los_flag in every cycle: it is 1 (reference clock) while loss is declared and 0 (recovered clock) otherwise.
- R6: While los_flag=1 and muting is enabled, out_pos and out_neg are both 0 whatever rx_pos and rx_neg carry.
- R7: mute_mode=0 takes the mute enable from mute_pin, and mute_mode=1 takes it from mute_reg. The selected value is registered and takes effect one clock edge after it is applied.
- R8: While los_flag=0, out_pos equals rx_pos and out_neg equals rx_neg, even with muting enabled.
- R9: After reset, los_flag=1, ref_clk_sel=1 and both counters are cleared, so 32 pulse UIs are needed before the first clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one unit interval per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rx_pos | input | 1 | Recovered positive pulse rail |
| rx_neg | input | 1 | Recovered negative pulse rail |
| decl_thresh | input | 8 | Zero-run length that declares loss (values below 10 act as 10) |
| mute_pin | input | 1 | Hardware mute enable |
| mute_reg | input | 1 | Register-bit mute enable |
| mute_mode | input | 1 | 0: use mute_pin, 1: use mute_reg |
| los_flag | output | 1 | Loss-of-signal condition |
| ref_clk_sel | output | 1 | 1 selects the reference clock, 0 the recovered clock |
| out_pos | output | 1 | Positive data rail after muting |
| out_neg | output | 1 | Negative data rail after muting |

## Verification
The assertions assume that reset has been released synchronously and that decl_thresh changes only while no zero run is in progress. A change in the middle of a run could declare loss at a count the assertions do not expect. The stimulus writes the threshold only right after reset or right after a clear, while the line is carrying pulses. All inputs are driven on the falling edge, so every UI is sampled with stable values.

// File: rtl/los_pkg.sv
package los_pkg;
  localparam int unsigned LOS_CNT_W      = 8;
  localparam int unsigned LOS_MIN_DECL   = 10;
  localparam int unsigned LOS_CLR_PULSES = 32;
  localparam int unsigned LOS_ZERO_RESET = 32;

  typedef enum logic {
    MUTE_FROM_PIN = 1'b0,
    MUTE_FROM_REG = 1'b1
  } mute_src_e;
endpackage

// File: rtl/los_run_counter.sv
module los_run_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse_i,
  output logic [CNT_W-1:0] run_o,
  output logic [CNT_W-1:0] run_next_o
);
  localparam logic [CNT_W-1:0] RUN_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] run_q;
  logic [CNT_W-1:0] run_d;

  always_comb begin
    if (pulse_i)               run_d = '0;
    else if (run_q == RUN_MAX) run_d = RUN_MAX;
    else                       run_d = run_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  assign run_o      = run_q;
  assign run_next_o = run_d;

  // R1
  pulse_clears_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_i |=> (run_q == '0));
endmodule

// File: rtl/los_pulse_counter.sv
module los_pulse_counter #(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned ZERO_RST = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic             pulse_i,
  input  logic [CNT_W-1:0] zero_run_next_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_next_o
);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] RST_RUN  = CNT_W'(ZERO_RST);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!enable_i)                      cnt_d = '0;
    else if (zero_run_next_i == RST_RUN) cnt_d = '0;
    else if (pulse_i && cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o      = cnt_q;
  assign cnt_next_o = cnt_d;

  // R4
  idle_holds_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> (cnt_q == '0));
endmodule

// File: rtl/los_mute_gate.sv
module los_mute_gate
  import los_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mode_i,
  input  logic pin_i,
  input  logic reg_i,
  input  logic los_i,
  input  logic rx_pos_i,
  input  logic rx_neg_i,
  output logic out_pos_o,
  output logic out_neg_o
);
  mute_src_e src;
  logic      mute_en_d;
  logic      mute_en_q;
  logic      mute_act;

  always_comb begin
    src       = mute_src_e'(mode_i);
    mute_en_d = (src == MUTE_FROM_REG) ? reg_i : pin_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mute_en_q <= 1'b0;
    else        mute_en_q <= mute_en_d;
  end

  assign mute_act  = los_i & mute_en_q;
  assign out_pos_o = rx_pos_i & ~mute_act;
  assign out_neg_o = rx_neg_i & ~mute_act;

  // R6
  muted_rails_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (los_i && mute_en_q) |-> (!out_pos_o && !out_neg_o));

  // R8
  pass_when_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !los_i |-> (out_pos_o == rx_pos_i && out_neg_o == rx_neg_i));
endmodule

// File: rtl/los_mute_detector.sv
module los_mute_detector
  import los_pkg::*;
#(
  parameter int unsigned CNT_W      = LOS_CNT_W,
  parameter int unsigned MIN_DECL   = LOS_MIN_DECL,
  parameter int unsigned CLR_PULSES = LOS_CLR_PULSES,
  parameter int unsigned ZERO_RST   = LOS_ZERO_RESET
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_pos,
  input  logic       rx_neg,
  input  logic [7:0] decl_thresh,
  input  logic       mute_pin,
  input  logic       mute_reg,
  input  logic       mute_mode,
  output logic       los_flag,
  output logic       ref_clk_sel,
  output logic       out_pos,
  output logic       out_neg
);
  localparam logic [CNT_W-1:0] MIN_T   = CNT_W'(MIN_DECL);
  localparam logic [CNT_W-1:0] CLR_T   = CNT_W'(CLR_PULSES);
  localparam logic [CNT_W-1:0] RST_RUN = CNT_W'(ZERO_RST);

  logic             pulse;
  logic [CNT_W-1:0] thr_eff;
  logic [CNT_W-1:0] zero_run;
  logic [CNT_W-1:0] zero_run_d;
  logic [CNT_W-1:0] pulse_cnt;
  logic [CNT_W-1:0] pulse_cnt_d;
  logic             los_q;
  logic             los_d;
  logic             sel_q;

  assign pulse = rx_pos | rx_neg;

  always_comb begin
    thr_eff = CNT_W'(decl_thresh);
    if (thr_eff < MIN_T) thr_eff = MIN_T;
  end

  los_run_counter #(.CNT_W(CNT_W)) zero_run_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pulse_i    (pulse),
    .run_o      (zero_run),
    .run_next_o (zero_run_d)
  );

  los_pulse_counter #(.CNT_W(CNT_W), .ZERO_RST(ZERO_RST)) pulse_cnt_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .enable_i        (los_q),
    .pulse_i         (pulse),
    .zero_run_next_i (zero_run_d),
    .cnt_o           (pulse_cnt),
    .cnt_next_o      (pulse_cnt_d)
  );

  always_comb begin
    if (los_q) los_d = (pulse_cnt_d < CLR_T);
    else       los_d = (zero_run_d >= thr_eff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      los_q <= 1'b1;
      sel_q <= 1'b1;
    end else begin
      los_q <= los_d;
      sel_q <= los_d;
    end
  end

  assign los_flag    = los_q;
  assign ref_clk_sel = sel_q;

  los_mute_gate mute_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (mute_mode),
    .pin_i     (mute_pin),
    .reg_i     (mute_reg),
    .los_i     (los_q),
    .rx_pos_i  (rx_pos),
    .rx_neg_i  (rx_neg),
    .out_pos_o (out_pos),
    .out_neg_o (out_neg)
  );

  // R5
  sel_tracks_los_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_clk_sel == los_flag);

  // R1
  declare_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(los_q) |-> (zero_run >= MIN_T));

  // R3
  clear_after_pulses_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(los_q) |-> ($past(pulse_cnt) >= CLR_T - 1'b1));

  // R4
  run_discards_pulses_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_run == RST_RUN) |-> (pulse_cnt == '0));
endmodule

// File: tb/los_mute_detector_tb.sv
`timescale 1ns/1ps
module los_mute_detector_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_pos, rx_neg;
  logic [7:0] decl_thresh;
  logic       mute_pin, mute_reg, mute_mode;
  logic       los_flag, ref_clk_sel, out_pos, out_neg;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  los_mute_detector dut_i (
    .clk(clk), .rst_n(rst_n), .rx_pos(rx_pos), .rx_neg(rx_neg),
    .decl_thresh(decl_thresh), .mute_pin(mute_pin), .mute_reg(mute_reg),
    .mute_mode(mute_mode), .los_flag(los_flag), .ref_clk_sel(ref_clk_sel),
    .out_pos(out_pos), .out_neg(out_neg)
  );

  // {pos, neg, UI count, expected los_flag}, threshold 32, no muting
  localparam logic [11:0] TBL [8] = '{
    {1'b1, 1'b0, 9'd31, 1'b1},  // R3: 31 pulses not enough
    {1'b1, 1'b0, 9'd1,  1'b0},  // R3: 32nd pulse clears
    {1'b0, 1'b0, 9'd31, 1'b0},  // R1: 31 zeros
    {1'b0, 1'b0, 9'd1,  1'b1},  // R1: 32nd zero declares
    {1'b0, 1'b1, 9'd20, 1'b1},  // R4: partial pulse count
    {1'b0, 1'b0, 9'd32, 1'b1},  // R4: 32 zeros discard it
    {1'b0, 1'b1, 9'd31, 1'b1},  // R4: count restarted from 0
    {1'b1, 1'b0, 9'd1,  1'b0}   // R4: 32nd fresh pulse clears
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_ui(input logic p, input logic n, input int cnt);
    rx_pos = p;
    rx_neg = n;
    repeat (cnt) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    rx_pos = 1'b0; rx_neg = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    decl_thresh = 8'd32;
    mute_pin = 1'b0; mute_reg = 1'b0; mute_mode = 1'b0;
    @(negedge clk);
    do_reset();
    chk("R9 los after reset", los_flag, 1);
    chk("R9 sel after reset", ref_clk_sel, 1);

    for (int i = 0; i < 8; i++) begin
      run_ui(TBL[i][11], TBL[i][10], int'(TBL[i][9:1]));
      chk($sformatf("R1/R3/R4 table step %0d los", i), los_flag, TBL[i][0]);
      chk($sformatf("R5 table step %0d sel", i), ref_clk_sel, TBL[i][0]);
    end

    // R7/R6: pin-sourced mute while declared
    do_reset();
    mute_mode = 1'b0; mute_pin = 1'b1; mute_reg = 1'b0;
    run_ui(1'b1, 1'b0, 1);
    chk("R6 muted out_pos", out_pos, 0);
    chk("R6 muted out_neg", out_neg, 0);
    // R7: switch to register source (0); takes effect after one edge
    mute_mode = 1'b1;
    rx_pos = 1'b0; rx_neg = 1'b1;
    #0.1;
    chk("R7 old select still muting", out_neg, 0);
    run_ui(1'b0, 1'b1, 1);
    chk("R7 reg source unmutes out_neg", out_neg, 1);
    chk("R7 still declared", los_flag, 1);
    mute_reg = 1'b1;
    run_ui(1'b1, 1'b1, 1);
    chk("R7 reg source mutes out_pos", out_pos, 0);

    // R8: cleared, mute enabled, data passes
    run_ui(1'b1, 1'b0, 29);
    chk("R8 cleared after 32 pulses", los_flag, 0);
    chk("R8 pass out_pos", out_pos, 1);
    run_ui(1'b0, 1'b1, 1);
    chk("R8 pass out_neg", out_neg, 1);

    // R2: threshold below 10 acts as 10
    mute_reg = 1'b0; mute_pin = 1'b0;
    decl_thresh = 8'd3;
    run_ui(1'b0, 1'b0, 9);
    chk("R2 9 zeros with thresh 3", los_flag, 0);
    run_ui(1'b0, 1'b0, 1);
    chk("R2 10th zero declares", los_flag, 1);

    // R2: maximum threshold 255
    run_ui(1'b1, 1'b0, 32);
    chk("R3 clear before max test", los_flag, 0);
    decl_thresh = 8'd255;
    run_ui(1'b0, 1'b0, 254);
    chk("R2 254 zeros with thresh 255", los_flag, 0);
    run_ui(1'b0, 1'b0, 1);
    chk("R2 255th zero declares", los_flag, 1);
    chk("R5 sel on declare", ref_clk_sel, 1);

    finish_run();
  end
endmodule